// File: doc/BRIEF.md
# Field Reset Detector with Half-Line Phase Selection

This block finds the start of each field from a vertical timing input (`va_in`) whose edges bear no fixed relation to the line timing. It has two ways of finding that moment. In edge mode the synchronised input is examined every system clock. The active edge, chosen as rising or falling by `edge_neg`, produces the field reset. In line-sampled mode the input is examined once per line, at one of two positions after the line-start strobe. The two positions lie half a line apart, so the reset can be moved by half a line in either direction. This is used to remove the half-line offset between odd and even interlaced fields.

A line is tracked by a position counter. The `ha_strobe` pulse clears it, and it wraps by itself after a full line when the strobe is missing. A field counter counts line starts since the last reset. It ignores a vertical event that comes too early in the field. When no event arrives, it forces a reset once the count reaches the maximum field length. At every reset it emits a one-clock `vreset` pulse. In the same cycle it presents the length of the field that just ended on `field_len`. That value is held until the next pulse. Both outputs are plain status pins with no handshake: `field_len` is valid from the `vreset` cycle onward and cannot be back-pressured.

Top module: `vsync_sampler`

## Requirements
- R1: After reset, `vreset` is 0 and `field_len` is 0.
- R2: In line-sampled mode (`deint_on`=1) with `phase_sel`=0, a detected event raises `vreset` in the clock where the line position is PHASE_A+1. Line position 0 is the clock edge that captured `ha_strobe`.
- R3: In line-sampled mode with `phase_sel`=1, the same holds at line position PHASE_B+1. PHASE_B-PHASE_A is half of LINE_CLKS.
- R4: In edge mode (`deint_on`=0), `vreset` rises on the third rising clock edge after an active `va_in` edge that was set up before the first of those edges.
- R5: `edge_neg`=0 makes the rising edge of `va_in` active and `edge_neg`=1 makes the falling edge active. The opposite edge produces no reset.
- R6: In line-sampled mode, an event is an active level at a sample point whose previous sample point saw the inactive level. An active pulse lying wholly between two sample points produces no reset.
- R7: An event arriving when fewer than MIN_LINES line starts have been counted since the last reset produces no reset.
- R8: When the count of line starts since the last reset reaches MAX_LINES without an accepted event, a reset is forced at that line start and `field_len` reports MAX_LINES.
- R9: `field_len` takes, in the `vreset` cycle, the number of line starts since the previous reset, including one that coincides with the reset edge. It does not change at any other time.
- R10: `vreset` is high for exactly one clock per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ha_strobe | input | 1 | One-clock line-start strobe |
| va_in | input | 1 | Vertical timing input, asynchronous |
| deint_on | input | 1 | 1 = line-sampled mode, 0 = edge mode |
| phase_sel | input | 1 | Sample position: 0 = PHASE_A, 1 = PHASE_B |
| edge_neg | input | 1 | 0 = rising edge active, 1 = falling edge active |
| vreset | output | 1 | One-clock field reset pulse |
| field_len | output | clog2(MAX_LINES+1) | Line count of the field just ended |

## Verification
The hardest case to reach is a vertical pulse that lands between the two sample points of a line. It is active long enough to be seen every clock in edge mode, yet invisible in line-sampled mode. The stimulus places `va_in` transitions at chosen line positions, counted from the bench's own line-start strobe. The bench shows a missed short pulse first, then a held pulse caught at the selected phase. The forced reset and the early-event window are reached by holding `va_in` still for whole fields. The parameters are scaled down so that a full field fits in a few hundred clocks.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef enum logic {
    SRC_EDGE = 1'b0,
    SRC_LINE = 1'b1
  } vsrc_e;
endpackage

// File: rtl/vs_va_sync.sv
module vs_va_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic va_in,
  input  logic edge_neg,
  output logic va_lvl
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= va_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  // normalise so that 1 is always the active level
  assign va_lvl = chain[STAGES-1] ^ edge_neg;
endmodule

// File: rtl/vs_line_pos.sv
module vs_line_pos #(
  parameter int LINE_CLKS = 432,
  parameter int PHASE_A   = 42,
  parameter int PHASE_B   = 258
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ha_strobe,
  input  logic phase_sel,
  output logic line_start,
  output logic samp_strobe
);
  localparam int PW = $clog2(LINE_CLKS);
  localparam logic [PW-1:0] LAST = PW'(LINE_CLKS - 1);
  localparam logic [PW-1:0] PA   = PW'(PHASE_A);
  localparam logic [PW-1:0] PB   = PW'(PHASE_B);

  logic [PW-1:0] pos_q;

  // a missing strobe still ends the line after LINE_CLKS clocks
  assign line_start  = ha_strobe | (pos_q == LAST);
  assign samp_strobe = (pos_q == (phase_sel ? PB : PA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos_q <= '0;
    else if (line_start) pos_q <= '0;
    else                 pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/vs_edge_pick.sv
module vs_edge_pick
  import vsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic va_lvl,
  input  logic samp_strobe,
  input  logic deint_on,
  output logic va_event
);
  logic  clk_prev_q;
  logic  samp_prev_q;
  logic  evt_edge;
  logic  evt_line;
  vsrc_e src;

  assign src      = deint_on ? SRC_LINE : SRC_EDGE;
  assign evt_edge = va_lvl & ~clk_prev_q;
  assign evt_line = samp_strobe & va_lvl & ~samp_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q  <= 1'b0;
      samp_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= va_lvl;
      if (samp_strobe) samp_prev_q <= va_lvl;
    end
  end

  always_comb begin
    unique case (src)
      SRC_LINE: va_event = evt_line;
      default:  va_event = evt_edge;
    endcase
  end
endmodule

// File: rtl/vs_field_ctr.sv
module vs_field_ctr #(
  parameter int MIN_LINES = 200,
  parameter int MAX_LINES = 910,
  parameter int CW        = $clog2(MAX_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          va_event,
  output logic          vreset,
  output logic [CW-1:0] field_len,
  output logic [CW-1:0] cur_lines
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          accept;
  logic          force_rst;
  logic          fire;

  assign cnt_inc   = cnt_q + CW'(line_start);
  assign accept    = va_event && (cnt_inc >= CW'(MIN_LINES));
  assign force_rst = line_start && (cnt_inc == CW'(MAX_LINES));
  assign fire      = accept | force_rst;
  assign cur_lines = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      field_len <= '0;
      vreset    <= 1'b0;
    end else begin
      vreset <= fire;
      if (fire) begin
        field_len <= cnt_inc;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/vsync_sampler.sv
module vsync_sampler #(
  parameter int LINE_CLKS   = 432,
  parameter int PHASE_A     = 42,
  parameter int PHASE_B     = 258,
  parameter int MIN_LINES   = 200,
  parameter int MAX_LINES   = 910,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ha_strobe,
  input  logic                           va_in,
  input  logic                           deint_on,
  input  logic                           phase_sel,
  input  logic                           edge_neg,
  output logic                           vreset,
  output logic [$clog2(MAX_LINES+1)-1:0] field_len
);
  localparam int CW = $clog2(MAX_LINES + 1);

  logic          va_lvl;
  logic          line_start;
  logic          samp_strobe;
  logic          va_event;
  logic [CW-1:0] cur_lines;

  vs_va_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .va_in    (va_in),
    .edge_neg (edge_neg),
    .va_lvl   (va_lvl)
  );

  vs_line_pos #(
    .LINE_CLKS (LINE_CLKS),
    .PHASE_A   (PHASE_A),
    .PHASE_B   (PHASE_B)
  ) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .ha_strobe   (ha_strobe),
    .phase_sel   (phase_sel),
    .line_start  (line_start),
    .samp_strobe (samp_strobe)
  );

  vs_edge_pick u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .va_lvl      (va_lvl),
    .samp_strobe (samp_strobe),
    .deint_on    (deint_on),
    .va_event    (va_event)
  );

  vs_field_ctr #(
    .MIN_LINES (MIN_LINES),
    .MAX_LINES (MAX_LINES),
    .CW        (CW)
  ) u_field (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .va_event   (va_event),
    .vreset     (vreset),
    .field_len  (field_len),
    .cur_lines  (cur_lines)
  );
endmodule

// File: rtl/vsync_sampler_chk.sv
module vsync_sampler_chk #(
  parameter int MIN_LINES = 200,
  parameter int MAX_LINES = 910,
  parameter int CW        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          deint_on,
  input logic          vreset,
  input logic [CW-1:0] field_len,
  input logic          samp_strobe,
  input logic          line_start,
  input logic [CW-1:0] cur_lines
);
  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |=> !vreset);

  assert_len_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vreset |-> $stable(field_len));

  assert_len_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |-> (field_len >= CW'(MIN_LINES)));

  assert_len_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |-> (field_len <= CW'(MAX_LINES)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lines < CW'(MAX_LINES));

  assert_line_sampled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vreset && $past(deint_on) && !$past(line_start)) |-> $past(samp_strobe));
endmodule

bind vsync_sampler vsync_sampler_chk #(
  .MIN_LINES (MIN_LINES),
  .MAX_LINES (MAX_LINES),
  .CW        (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .deint_on    (deint_on),
  .vreset      (vreset),
  .field_len   (field_len),
  .samp_strobe (samp_strobe),
  .line_start  (line_start),
  .cur_lines   (cur_lines)
);

// File: tb/vsync_sampler_tb.sv
module vsync_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L    = 32;
  localparam int PA   = 3;
  localparam int PB   = 19;
  localparam int MINL = 4;
  localparam int MAXL = 12;
  localparam int LW   = $clog2(MAXL + 1);

  typedef struct {
    int    len;
    int    pos;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ha = 1'b0;
  logic va = 1'b0;
  logic deint_on = 1'b0;
  logic phase_sel = 1'b0;
  logic edge_neg = 1'b0;
  logic vreset;
  logic [LW-1:0] field_len;

  int   total = 0;
  int   bad = 0;
  int   hcnt = 1;
  int   tpos = 0;
  int   lines = 0;
  int   seen = 0;
  bit   rel_ok = 1'b0;
  bit   prev_vr = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_sampler #(
    .LINE_CLKS (L), .PHASE_A (PA), .PHASE_B (PB),
    .MIN_LINES (MINL), .MAX_LINES (MAXL), .SYNC_STAGES (2)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .ha_strobe (ha), .va_in (va),
    .deint_on (deint_on), .phase_sel (phase_sel), .edge_neg (edge_neg),
    .vreset (vreset), .field_len (field_len)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor, line model and strobe generator in one place
  always @(negedge clk) begin
    if (!rst_n) begin
      if (rel_ok && ha) begin
        rst_n = 1'b1;
        tpos = 0;
        lines = 0;
      end
    end else begin
      if (ha) begin
        lines++;
        tpos = 0;
      end else begin
        tpos++;
      end
      if (vreset) begin
        seen++;
        check(!prev_vr, "R10", "vreset width", 2, 1);
        if (sb.size() == 0) begin
          check(1'b0, "R5/R6/R7", "unexpected vreset at pos", tpos, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(field_len) == e.len, e.tag, "field_len", int'(field_len), e.len);
          check(tpos == e.pos, e.tag, "reset line position", tpos, e.pos);
        end
        lines = 0;
      end
      prev_vr = vreset;
    end
    hcnt = (hcnt == L - 1) ? 0 : hcnt + 1;
    ha = (hcnt == 0);
  end

  task automatic wait_at(input int ln, input int ps);
    do begin
      @(negedge clk);
      #1;
    end while (!(lines == ln && tpos == ps));
  endtask

  task automatic push(input int len, input int pos, input string tag);
    exp_t e;
    e.len = len;
    e.pos = pos;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_drain();
    while (sb.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_all();
    int n;
    repeat (5) @(negedge clk);
    rel_ok = 1'b1;
    wait (rst_n == 1'b1);
    #2;
    check(vreset == 1'b0, "R1", "vreset after reset", int'(vreset), 0);
    check(field_len == '0, "R1", "field_len after reset", int'(field_len), 0);

    // edge mode, rising edge active
    wait_at(5, 8); va = 1'b1; push(5, 11, "R4");
    wait_drain();
    wait_at(2, 8); n = seen; va = 1'b0;           // falling edge: inactive
    wait_at(3, 0);
    check(seen == n, "R5", "resets after inactive edge", seen - n, 0);
    wait_at(6, 10); va = 1'b1; push(6, 13, "R9");
    wait_drain();

    // falling edge active
    wait_at(1, 5); edge_neg = 1'b1;               // va=1 is now inactive
    wait_at(5, 4); va = 1'b0; push(5, 7, "R5");
    wait_drain();

    // early event ignored, then two forced resets
    wait_at(2, 6); n = seen; va = 1'b1;
    wait_at(2, 20); va = 1'b0;                    // active edge at line 2
    wait_at(3, 0);
    check(seen == n, "R7", "resets after early event", seen - n, 0);
    push(MAXL, 0, "R8");
    push(MAXL, 0, "R8");
    wait_drain();

    // line-sampled mode, first phase
    wait_at(1, 5); edge_neg = 1'b0; deint_on = 1'b1; phase_sel = 1'b0;
    wait_at(5, 10); va = 1'b1; push(6, PA + 1, "R2");
    wait_drain();
    wait_at(1, 10); va = 1'b0;

    // second phase, half a line later
    wait_at(1, 12); phase_sel = 1'b1;
    wait_at(5, 10); va = 1'b1; push(5, PB + 1, "R3");
    wait_drain();
    wait_at(1, 25); va = 1'b0;

    // a short pulse between sample points is missed
    wait_at(5, 22); n = seen; va = 1'b1;
    wait_at(5, 28); va = 1'b0;
    wait_at(6, 21);
    check(seen == n, "R6", "resets after short pulse", seen - n, 0);
    wait_at(7, 2); va = 1'b1; push(7, PB + 1, "R6");
    wait_drain();
    wait_at(1, 25); va = 1'b0;

    // length is held between resets
    wait_at(3, 0);
    check(int'(field_len) == 7, "R9", "field_len held", int'(field_len), 7);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (40000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish, cycles", 40000, 0);
      end
    join_any
    disable fork;
    check(sb.size() == 0, "R9", "outstanding expected resets", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule